// File: doc/BRIEF.md
# NAND Flash Command Front-End

This block sits on the device side of a parallel NAND flash bus. On each clock edge where the host write strobe is high and the chip is selected, it classifies the bus word as a command byte (CLE high), an address byte (ALE high) or a data word (both low). Command bytes steer a small mode machine. Address bytes build a byte-addressed operation address, least significant byte first. When enough address cycles have arrived, or when a confirm command is seen, the block posts a load, program or erase request to an attached page array.

On the read side, every host read strobe updates a registered output word. The word comes from one of three sources: the status byte, the identification sequence, or the array's data for the current column. Each word taken from the array raises a one-cycle advance pulse back to the array.

The page geometry, the bus width and the device size are fixed by parameters. Together they set the cycle at which a read starts, how an erase address is shifted, which read aliases exist and the fourth identification byte. Operation requests leave on a valid/ready port. A pending request holds its kind and address steady until it is accepted. A new request that arrives while the old one is pending and not accepted is dropped. A request accepted in the same cycle that a new one is launched frees the slot for the new one. Program data leaves as a plain one-cycle strobe with no back-pressure.

Top module: `nand_cmd_frontend`

## Requirements
- R1: After reset the read word is 0 and no request is pending. A status read then returns 0xC0 while the protect pin is high.
- R2: After opcode 0x90 and one address byte, successive reads return these bytes, each zero-extended on a 16-bit bus:
  - the manufacturer code;
  - the device code;
  - the filler 0x5A;
  - 0x15 (large page, 8-bit), 0x55 (large page, 16-bit) or 0xC0 (small page).

  Every later read returns 0.
- R3: After opcode 0x70 every read returns the status byte until another command arrives. In the status byte, bit 0 (error) is 0, bit 6 (ready) is 1 and bit 7 follows the protect pin live.
- R4: After opcode 0x00, a load request is posted in the cycle the last required address byte is taken. That is the 3rd byte on small-page parts, the 4th on large-page parts of 1 Gbit or less, and the 5th on larger parts. The request has op_kind 1 and carries the address assembled LSB first. After the load, each read returns arr_rdata and pulses arr_next.
- R5: On small-page parts, opcode 0x01 adds 0x100 to the loaded address and opcode 0x50 adds the page size; both otherwise behave as 0x00.
- R6: On large-page parts, 0x30 received while reading changes nothing. 0x05 clears the two column bytes and restarts the address count. 0xE0 posts a load at the current address and keeps reading.
- R7: After opcode 0x80 and the launch-count address bytes, each data word pulses wdat_valid with that word. Opcode 0x10 then posts a program request (op_kind 2) at the collected address.
- R8: Opcode 0x60 followed by row bytes and 0xD0 posts an erase request (op_kind 3). Its address is the collected bytes, masked to the number received, then shifted left by 16 on large-page parts or by 8 on small-page parts.
- R9: While the protect pin is low, 0x10 and 0xD0 post no request.
- R10: Opcode 0xFF makes read the current mode, clears the address and the address count, and drops the status mode; a read that follows returns 0.
- R11: While ce_n is high, a read returns 0 and bus writes have no effect.
- R12: An opcode outside the supported set leaves the mode, address and outputs unchanged.
- R13: A pending request keeps op_valid, op_kind and op_addr stable until op_ready. A launch during a pending, unaccepted request is dropped. A launch in the cycle the pending one is accepted replaces it.
- R14: On a 16-bit bus the address collected so far is shifted left by one when the second address byte is taken, so the column becomes a byte address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ce_n | input | 1 | Active-low chip select |
| cle | input | 1 | Command latch qualifier |
| ale | input | 1 | Address latch qualifier |
| wp_n | input | 1 | Active-low write protect |
| bus_we | input | 1 | Host write strobe |
| bus_re | input | 1 | Host read strobe |
| bus_din | input | BUS_W | Host write word |
| bus_dout | output | BUS_W | Registered read word |
| op_valid | output | 1 | Operation request pending |
| op_ready | input | 1 | Array accepts the request |
| op_kind | output | 2 | 1 load, 2 program, 3 erase |
| op_addr | output | 8*MAX_ACYC | Byte address of the request |
| wdat_valid | output | 1 | Program data strobe |
| wdat | output | BUS_W | Program data word |
| arr_rdata | input | BUS_W | Array word at the current column |
| arr_next | output | 1 | Array word consumed |

## Verification
Two functions can land in the same cycle: a new launch and the array accepting an older request. The bench holds op_ready low so that a load stays pending. It then raises op_ready on exactly the edge that carries a 0xE0 command. The judgement is that the older address is logged as accepted and the new address is left pending. A second launch made while op_ready stays low must leave the pending address untouched.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;
  typedef enum logic [1:0] {OPK_NONE, OPK_LOAD, OPK_PROG, OPK_ERASE} opk_e;
  typedef enum logic [2:0] {MD_READ, MD_ID, MD_PROG, MD_ERASE, MD_STATUS, MD_DONE} mode_e;

  localparam logic [7:0] OPC_READ       = 8'h00;
  localparam logic [7:0] OPC_READ_HI    = 8'h01;
  localparam logic [7:0] OPC_READ_SPARE = 8'h50;
  localparam logic [7:0] OPC_RD_CONFIRM = 8'h30;
  localparam logic [7:0] OPC_COL_CHANGE = 8'h05;
  localparam logic [7:0] OPC_COL_LOAD   = 8'hE0;
  localparam logic [7:0] OPC_IDENT      = 8'h90;
  localparam logic [7:0] OPC_RESET      = 8'hFF;
  localparam logic [7:0] OPC_PROG       = 8'h80;
  localparam logic [7:0] OPC_PROG_GO    = 8'h10;
  localparam logic [7:0] OPC_ERASE      = 8'h60;
  localparam logic [7:0] OPC_ERASE_GO   = 8'hD0;
  localparam logic [7:0] OPC_STATUS     = 8'h70;
endpackage

// File: rtl/nand_addr_collect.sv
module nand_addr_collect #(
  parameter int BUS16    = 0,
  parameter int COL_BITS = 16,
  parameter int MAX_ACYC = 5,
  localparam int AW      = 8 * MAX_ACYC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          take,
  input  logic [7:0]    byte_in,
  input  logic          clr_cnt,
  input  logic          clr_col,
  input  logic          clr_all,
  output logic [AW-1:0] addr_q,
  output logic [2:0]    cnt_q,
  output logic [AW-1:0] addr_nx,
  output logic [2:0]    cnt_nx
);
  always_comb begin
    addr_nx = addr_q;
    cnt_nx  = cnt_q;
    if (clr_all) begin
      addr_nx = '0;
      cnt_nx  = '0;
    end else if (clr_col) begin
      addr_nx[COL_BITS-1:0] = '0;
      cnt_nx = '0;
    end else if (clr_cnt) begin
      cnt_nx = '0;
    end
    if (take) begin
      for (int i = 0; i < MAX_ACYC; i++) begin
        if (cnt_q == 3'(i)) addr_nx[i*8 +: 8] = byte_in;
      end
      if (cnt_q != 3'd7) cnt_nx = cnt_q + 3'd1;
      if (BUS16 != 0 && cnt_q == 3'd1) addr_nx = addr_nx << 1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_nx;
      cnt_q  <= cnt_nx;
    end
  end
endmodule

// File: rtl/nand_rd_mux.sv
module nand_rd_mux
  import nand_fe_pkg::*;
#(
  parameter int         BUS_W      = 8,
  parameter int         LARGE_PAGE = 1,
  parameter logic [7:0] MANUF_ID   = 8'hEC,
  parameter logic [7:0] DEVICE_ID  = 8'hF1,
  parameter logic [7:0] FILLER     = 8'h5A
) (
  input  mode_e             mode,
  input  logic              id_on,
  input  logic [2:0]        id_idx,
  input  logic              wp_n,
  input  logic              loaded,
  input  logic [BUS_W-1:0]  arr_rdata,
  output logic [BUS_W-1:0]  word,
  output logic              from_array
);
  localparam logic [7:0] GEOM_BYTE =
    (LARGE_PAGE != 0) ? ((BUS_W == 16) ? 8'h55 : 8'h15) : 8'hC0;

  logic [7:0] id_byte;
  logic [7:0] status_byte;

  always_comb begin
    case (id_idx)
      3'd0:    id_byte = MANUF_ID;
      3'd1:    id_byte = DEVICE_ID;
      3'd2:    id_byte = FILLER;
      3'd3:    id_byte = GEOM_BYTE;
      default: id_byte = 8'h00;
    endcase
  end

  assign status_byte = {wp_n, 1'b1, 6'b000000};

  always_comb begin
    word       = '0;
    from_array = 1'b0;
    case (mode)
      MD_STATUS: word[7:0] = status_byte;
      MD_ID:     if (id_on) word[7:0] = id_byte;
      MD_READ:   if (loaded) begin
                   word       = arr_rdata;
                   from_array = 1'b1;
                 end
      default:   ;
    endcase
  end
endmodule

// File: rtl/nand_op_req.sv
module nand_op_req #(
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          launch,
  input  logic [1:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic          op_ready,
  output logic          op_valid,
  output logic [1:0]    op_kind,
  output logic [AW-1:0] op_addr
);
  logic slot_free;
  assign slot_free = !op_valid || op_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op_valid <= 1'b0;
      op_kind  <= '0;
      op_addr  <= '0;
    end else begin
      if (op_valid && op_ready) op_valid <= 1'b0;
      if (launch && slot_free) begin
        op_valid <= 1'b1;
        op_kind  <= kind;
        op_addr  <= addr;
      end
    end
  end
endmodule

// File: rtl/nand_cmd_frontend.sv
module nand_cmd_frontend
  import nand_fe_pkg::*;
#(
  parameter int         BUS_W      = 8,
  parameter int         LARGE_PAGE = 1,
  parameter int         BIG_DEVICE = 0,
  parameter int         PAGE_BYTES = 2048,
  parameter int         MAX_ACYC   = 5,
  parameter logic [7:0] MANUF_ID   = 8'hEC,
  parameter logic [7:0] DEVICE_ID  = 8'hF1,
  parameter logic [7:0] FILLER     = 8'h5A
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_n,
  input  logic                  cle,
  input  logic                  ale,
  input  logic                  wp_n,
  input  logic                  bus_we,
  input  logic                  bus_re,
  input  logic [BUS_W-1:0]      bus_din,
  output logic [BUS_W-1:0]      bus_dout,
  output logic                  op_valid,
  input  logic                  op_ready,
  output logic [1:0]            op_kind,
  output logic [8*MAX_ACYC-1:0] op_addr,
  output logic                  wdat_valid,
  output logic [BUS_W-1:0]      wdat,
  input  logic [BUS_W-1:0]      arr_rdata,
  output logic                  arr_next
);
  localparam int AW          = 8 * MAX_ACYC;
  localparam int BUS16       = (BUS_W == 16) ? 1 : 0;
  localparam int COL_BITS    = (LARGE_PAGE != 0) ? 16 : 8;
  localparam int LAUNCH_CYC  = (LARGE_PAGE != 0) ? ((BIG_DEVICE != 0) ? 5 : 4) : 3;
  localparam int ERASE_SHIFT = (LARGE_PAGE != 0) ? 16 : 8;
  localparam logic [AW-1:0] HI_HALF = AW'(256);
  localparam logic [AW-1:0] SPARE   = AW'(PAGE_BYTES);

  logic       wr_cmd, wr_adr, wr_dat, rd_go;
  logic [7:0] cb;
  assign wr_cmd = bus_we && !ce_n && cle && !ale;
  assign wr_adr = bus_we && !ce_n && ale && !cle;
  assign wr_dat = bus_we && !ce_n && !cle && !ale;
  assign rd_go  = bus_re && !ce_n;
  assign cb     = bus_din[7:0];

  mode_e         mode_q, mode_d;
  logic [AW-1:0] ofs_q, ofs_d;
  logic          loaded_q, loaded_d, armed_q, armed_d, id_on_q, id_on_d;
  logic [2:0]    id_idx_q, id_idx_d;

  logic          clr_cnt, clr_col, clr_all;
  logic [AW-1:0] addr_q, addr_nx, emask, erase_addr;
  logic [2:0]    cnt_q, cnt_nx;

  logic          launch;
  opk_e          lkind;
  logic [AW-1:0] laddr;

  logic [BUS_W-1:0] mux_word;
  logic             mux_from_arr;

  nand_addr_collect #(.BUS16(BUS16), .COL_BITS(COL_BITS), .MAX_ACYC(MAX_ACYC)) u_addr (
    .clk(clk), .rst_n(rst_n), .take(wr_adr), .byte_in(cb),
    .clr_cnt(clr_cnt), .clr_col(clr_col), .clr_all(clr_all),
    .addr_q(addr_q), .cnt_q(cnt_q), .addr_nx(addr_nx), .cnt_nx(cnt_nx)
  );

  nand_rd_mux #(.BUS_W(BUS_W), .LARGE_PAGE(LARGE_PAGE), .MANUF_ID(MANUF_ID),
                .DEVICE_ID(DEVICE_ID), .FILLER(FILLER)) u_mux (
    .mode(mode_q), .id_on(id_on_q), .id_idx(id_idx_q), .wp_n(wp_n),
    .loaded(loaded_q), .arr_rdata(arr_rdata), .word(mux_word), .from_array(mux_from_arr)
  );

  nand_op_req #(.AW(AW)) u_req (
    .clk(clk), .rst_n(rst_n), .launch(launch), .kind(lkind), .addr(laddr),
    .op_ready(op_ready), .op_valid(op_valid), .op_kind(op_kind), .op_addr(op_addr)
  );

  // Erase address: only the bytes actually received, widened to a byte address.
  always_comb begin
    emask = '0;
    for (int i = 0; i < MAX_ACYC; i++) begin
      if (3'(i) < cnt_q) emask[i*8 +: 8] = 8'hFF;
    end
    erase_addr = (addr_q & emask) << ERASE_SHIFT;
  end

  always_comb begin
    mode_d   = mode_q;
    ofs_d    = ofs_q;
    loaded_d = loaded_q;
    armed_d  = armed_q;
    id_on_d  = id_on_q;
    id_idx_d = id_idx_q;
    clr_cnt  = 1'b0;
    clr_col  = 1'b0;
    clr_all  = 1'b0;
    launch   = 1'b0;
    lkind    = OPK_NONE;
    laddr    = '0;

    if (rd_go && mode_q == MD_ID && id_on_q && id_idx_q != 3'd7)
      id_idx_d = id_idx_q + 3'd1;

    if (wr_cmd) begin
      if (LARGE_PAGE != 0 && mode_q == MD_READ && cb == OPC_RD_CONFIRM) begin
        // confirm byte of a large-page read: nothing to do
      end else if (LARGE_PAGE != 0 && cb == OPC_COL_CHANGE) begin
        clr_col = 1'b1;
      end else if (LARGE_PAGE != 0 && cb == OPC_COL_LOAD) begin
        launch   = 1'b1;
        lkind    = OPK_LOAD;
        laddr    = addr_q;
        mode_d   = MD_READ;
        loaded_d = 1'b1;
      end else begin
        case (cb)
          OPC_READ: begin
            mode_d = MD_READ; ofs_d = '0; loaded_d = 1'b0; clr_cnt = 1'b1;
          end
          OPC_READ_HI: if (LARGE_PAGE == 0) begin
            mode_d = MD_READ; ofs_d = HI_HALF; loaded_d = 1'b0; clr_cnt = 1'b1;
          end
          OPC_READ_SPARE: if (LARGE_PAGE == 0) begin
            mode_d = MD_READ; ofs_d = SPARE; loaded_d = 1'b0; clr_cnt = 1'b1;
          end
          OPC_IDENT: begin
            mode_d = MD_ID; id_on_d = 1'b0; loaded_d = 1'b0; clr_cnt = 1'b1;
          end
          OPC_RESET: begin
            mode_d = MD_READ; ofs_d = '0; loaded_d = 1'b0; armed_d = 1'b0;
            id_on_d = 1'b0; clr_all = 1'b1;
          end
          OPC_PROG: begin
            mode_d = MD_PROG; armed_d = 1'b0; loaded_d = 1'b0; clr_cnt = 1'b1;
          end
          OPC_PROG_GO: begin
            if (mode_q == MD_PROG && armed_q && wp_n) begin
              launch = 1'b1; lkind = OPK_PROG; laddr = addr_q;
            end
            mode_d = MD_DONE; armed_d = 1'b0; clr_cnt = 1'b1;
          end
          OPC_ERASE: begin
            mode_d = MD_ERASE; loaded_d = 1'b0; clr_cnt = 1'b1;
          end
          OPC_ERASE_GO: begin
            if (mode_q == MD_ERASE && wp_n) begin
              launch = 1'b1; lkind = OPK_ERASE; laddr = erase_addr;
            end
            mode_d = MD_DONE; clr_cnt = 1'b1;
          end
          OPC_STATUS: begin
            mode_d = MD_STATUS; clr_cnt = 1'b1;
          end
          default: ;
        endcase
      end
    end else if (wr_adr) begin
      if (cnt_nx == 3'(LAUNCH_CYC)) begin
        if (mode_q == MD_READ) begin
          launch   = 1'b1;
          lkind    = OPK_LOAD;
          laddr    = addr_nx + ofs_q;
          loaded_d = 1'b1;
          ofs_d    = '0;
        end else if (mode_q == MD_PROG) begin
          armed_d = 1'b1;
        end
      end
      if (mode_q == MD_ID && cnt_nx == 3'd1) begin
        id_on_d  = 1'b1;
        id_idx_d = 3'd0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= MD_READ;
      ofs_q      <= '0;
      loaded_q   <= 1'b0;
      armed_q    <= 1'b0;
      id_on_q    <= 1'b0;
      id_idx_q   <= '0;
      bus_dout   <= '0;
      arr_next   <= 1'b0;
      wdat_valid <= 1'b0;
      wdat       <= '0;
    end else begin
      mode_q     <= mode_d;
      ofs_q      <= ofs_d;
      loaded_q   <= loaded_d;
      armed_q    <= armed_d;
      id_on_q    <= id_on_d;
      id_idx_q   <= id_idx_d;
      arr_next   <= rd_go && mux_from_arr;
      wdat_valid <= wr_dat && mode_q == MD_PROG && armed_q;
      if (wr_dat && mode_q == MD_PROG && armed_q) wdat <= bus_din;
      if (rd_go) bus_dout <= mux_word;
      else if (bus_re) bus_dout <= '0;
    end
  end
endmodule

// File: rtl/nand_fe_checker.sv
module nand_fe_checker
  import nand_fe_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int AW    = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_re,
  input logic             bus_we,
  input logic             cle,
  input logic             ale,
  input logic             ce_n,
  input logic             wp_n,
  input logic [BUS_W-1:0] bus_dout,
  input logic             op_valid,
  input logic             op_ready,
  input logic [1:0]       op_kind,
  input logic [AW-1:0]    op_addr,
  input logic             wdat_valid,
  input logic             arr_next,
  input logic [2:0]       mode_q
);
  // R13: a request waiting for the array keeps its contents
  a_r13_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && !op_ready |=> op_valid && $stable(op_kind) && $stable(op_addr));

  // R11: a deselected read yields zero
  a_r11_deselect_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && ce_n |=> bus_dout == '0);

  // R3: status word fields
  a_r3_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re && !ce_n && mode_q == 3'(MD_STATUS) |=>
      bus_dout[6] && !bus_dout[0] && bus_dout[7] == $past(wp_n));

  // R9: program or erase requests only appear with protect released
  a_r9_protect_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(op_valid) && op_kind != 2'd1 |-> $past(wp_n));

  // R7: program data strobe follows a selected data-cycle write
  a_r7_wdat_source: assert property (@(posedge clk) disable iff (!rst_n)
    wdat_valid |-> $past(bus_we && !cle && !ale && !ce_n));

  // R4: array advance only follows a selected read
  a_r4_arr_step: assert property (@(posedge clk) disable iff (!rst_n)
    arr_next |-> $past(bus_re && !ce_n));
endmodule

bind nand_cmd_frontend nand_fe_checker #(.BUS_W(BUS_W), .AW(8*MAX_ACYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_re(bus_re), .bus_we(bus_we), .cle(cle), .ale(ale),
  .ce_n(ce_n), .wp_n(wp_n), .bus_dout(bus_dout), .op_valid(op_valid),
  .op_ready(op_ready), .op_kind(op_kind), .op_addr(op_addr),
  .wdat_valid(wdat_valid), .arr_next(arr_next), .mode_q(mode_q)
);

// File: tb/tb_nand_cmd_frontend.sv
module tb_nand_cmd_frontend;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_NS/2) clk = ~clk;

  logic        bus_we = 0, bus_re = 0, cle = 0, ale = 0, ce_n = 1, ce2_n = 1, wp_n = 1;
  logic [15:0] din = '0;
  logic        op_ready = 1'b1;

  logic [7:0]  dout, wdat;
  logic        op_valid, wdat_valid, arr_next;
  logic [1:0]  op_kind;
  logic [39:0] op_addr;

  logic [15:0] dout2, wdat2;
  logic        op_valid2, wdat_valid2, arr_next2;
  logic [1:0]  op_kind2;
  logic [39:0] op_addr2;

  nand_cmd_frontend dut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cle(cle), .ale(ale), .wp_n(wp_n),
    .bus_we(bus_we), .bus_re(bus_re), .bus_din(din[7:0]), .bus_dout(dout),
    .op_valid(op_valid), .op_ready(op_ready), .op_kind(op_kind), .op_addr(op_addr),
    .wdat_valid(wdat_valid), .wdat(wdat), .arr_rdata(8'hA7), .arr_next(arr_next)
  );

  nand_cmd_frontend #(.BUS_W(16), .LARGE_PAGE(0), .PAGE_BYTES(512), .DEVICE_ID(8'h49)) dut_sp (
    .clk(clk), .rst_n(rst_n), .ce_n(ce2_n), .cle(cle), .ale(ale), .wp_n(wp_n),
    .bus_we(bus_we), .bus_re(bus_re), .bus_din(din), .bus_dout(dout2),
    .op_valid(op_valid2), .op_ready(1'b1), .op_kind(op_kind2), .op_addr(op_addr2),
    .wdat_valid(wdat_valid2), .wdat(wdat2), .arr_rdata(16'h1234), .arr_next(arr_next2)
  );

  int          n_ops = 0, n_ops2 = 0, n_wdat = 0, n_arr = 0;
  logic [1:0]  last_kind = '0, last_kind2 = '0;
  logic [39:0] last_addr = '0, last_addr2 = '0;
  logic [7:0]  last_wdat = '0;

  always @(posedge clk) begin
    if (rst_n) begin
      if (op_valid && op_ready) begin n_ops <= n_ops + 1; last_kind <= op_kind; last_addr <= op_addr; end
      if (op_valid2) begin n_ops2 <= n_ops2 + 1; last_kind2 <= op_kind2; last_addr2 <= op_addr2; end
      if (wdat_valid) begin n_wdat <= n_wdat + 1; last_wdat <= wdat; end
      if (arr_next) n_arr <= n_arr + 1;
    end
  end

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic c, input logic a, input logic [15:0] d);
    @(negedge clk); bus_we = 1; cle = c; ale = a; din = d;
    @(negedge clk); bus_we = 0; cle = 0; ale = 0;
  endtask
  task automatic cmd(input logic [7:0] b); wr(1'b1, 1'b0, {8'h00, b}); endtask
  task automatic adr(input logic [7:0] b); wr(1'b0, 1'b1, {8'h00, b}); endtask
  task automatic dat(input logic [15:0] d); wr(1'b0, 1'b0, d); endtask
  task automatic rd(output logic [15:0] v);
    @(negedge clk); bus_re = 1;
    @(negedge clk); bus_re = 0;
    v = ce2_n ? {8'h00, dout} : dout2;
  endtask
  task automatic settle(); @(negedge clk); @(negedge clk); endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 dout after reset", dout, 0);
    chk("R1 no request after reset", op_valid, 0);
    cmd(8'h70); rd(v);
    chk("R1 status after reset", v, 16'h00C0);
  endtask

  task automatic t_status();
    logic [15:0] v;
    cmd(8'h70); rd(v); rd(v);
    chk("R3 sticky status", v, 16'h00C0);
    wp_n = 0; rd(v);
    chk("R3 protect bit follows pin", v, 16'h0040);
    wp_n = 1;
    cmd(8'h42); rd(v);
    chk("R12 unknown opcode keeps status mode", v, 16'h00C0);
  endtask

  task automatic t_deselect();
    logic [15:0] v;
    ce_n = 1; rd(v);
    chk("R11 deselected read is zero", v, 0);
    cmd(8'h00);
    ce_n = 0; rd(v);
    chk("R11 deselected write ignored", v, 16'h00C0);
  endtask

  task automatic t_ident();
    logic [15:0] v;
    cmd(8'h90); adr(8'h00);
    rd(v); chk("R2 id byte 0", v, 16'h00EC);
    rd(v); chk("R2 id byte 1", v, 16'h00F1);
    rd(v); chk("R2 id byte 2", v, 16'h005A);
    rd(v); chk("R2 id byte 3 large x8", v, 16'h0015);
    rd(v); chk("R2 after id", v, 0);
  endtask

  task automatic t_read_large();
    logic [15:0] v;
    int n0, a0;
    n0 = n_ops;
    cmd(8'h00); adr(8'h12); adr(8'h03); adr(8'h45); settle();
    chk("R4 no load before 4th cycle", n_ops, n0);
    adr(8'h06); settle();
    chk("R4 load count", n_ops, n0 + 1);
    chk("R4 load kind", last_kind, 2'd1);
    chk("R4 load addr", last_addr, 40'h0006450312);
    cmd(8'h30);
    a0 = n_arr;
    rd(v); settle();
    chk("R6 0x30 ignored, array data", v, 16'h00A7);
    chk("R4 array advance", n_arr, a0 + 1);
    cmd(8'h05); adr(8'h34); adr(8'h01); cmd(8'hE0); settle();
    chk("R6 column change reload", last_addr, 40'h0006450134);
    chk("R6 reload count", n_ops, n0 + 2);
  endtask

  task automatic t_reset_cmd();
    logic [15:0] v;
    cmd(8'h00); adr(8'h11); adr(8'h22); adr(8'h33);
    cmd(8'h70); cmd(8'hFF); rd(v);
    chk("R10 reset leaves status mode", v, 0);
    cmd(8'h05); adr(8'h10); adr(8'h00); cmd(8'hE0); settle();
    chk("R10 address cleared by reset", last_addr, 40'h10);
  endtask

  task automatic t_program();
    int n0, w0;
    n0 = n_ops; w0 = n_wdat;
    cmd(8'h80); adr(8'h00); adr(8'h02); adr(8'h07); adr(8'h00);
    dat(16'h00AB); dat(16'h00CD); settle();
    chk("R7 data strobes", n_wdat, w0 + 2);
    chk("R7 last data", last_wdat, 8'hCD);
    cmd(8'h10); settle();
    chk("R7 program kind", last_kind, 2'd2);
    chk("R7 program addr", last_addr, 40'h0000070200);
    wp_n = 0;
    cmd(8'h80); adr(8'h00); adr(8'h02); adr(8'h07); adr(8'h00); cmd(8'h10); settle();
    chk("R9 program blocked", n_ops, n0 + 1);
    wp_n = 1;
  endtask

  task automatic t_erase();
    int n0;
    n0 = n_ops;
    cmd(8'h60); adr(8'h22); adr(8'h01); cmd(8'hD0); settle();
    chk("R8 erase kind", last_kind, 2'd3);
    chk("R8 erase addr", last_addr, 40'h0001220000);
    wp_n = 0;
    cmd(8'h60); adr(8'h22); adr(8'h01); cmd(8'hD0); settle();
    chk("R9 erase blocked", n_ops, n0 + 1);
    wp_n = 1;
  endtask

  task automatic t_handshake();
    int n0;
    n0 = n_ops;
    op_ready = 0;
    cmd(8'h00); adr(8'h01); adr(8'h02); adr(8'h03); adr(8'h04); settle();
    chk("R13 pending valid", op_valid, 1);
    chk("R13 pending addr", op_addr, 40'h0004030201);
    cmd(8'h05); adr(8'h00); adr(8'h00); cmd(8'hE0); settle();
    chk("R13 launch dropped while pending", op_addr, 40'h0004030201);
    @(negedge clk); op_ready = 1; bus_we = 1; cle = 1; din = 16'h00E0;
    @(negedge clk); bus_we = 0; cle = 0; op_ready = 0;
    chk("R13 accept and launch same cycle valid", op_valid, 1);
    chk("R13 replacement addr", op_addr, 40'h0004030000);
    chk("R13 older request accepted", last_addr, 40'h0004030201);
    op_ready = 1; settle();
    chk("R13 drained", op_valid, 0);
    chk("R13 accepted count", n_ops, n0 + 2);
  endtask

  task automatic t_small();
    logic [15:0] v;
    int n0;
    ce_n = 1; ce2_n = 0;
    cmd(8'h90); adr(8'h00);
    rd(v); chk("R2 x16 id byte 0", v, 16'h00EC);
    rd(v); chk("R2 x16 id byte 1", v, 16'h0049);
    rd(v); chk("R2 x16 id byte 2", v, 16'h005A);
    rd(v); chk("R2 small page id byte 3", v, 16'h00C0);
    n0 = n_ops2;
    cmd(8'h01); adr(8'h10); adr(8'h02); settle();
    chk("R4 small page no load after 2 cycles", n_ops2, n0);
    adr(8'h03); settle();
    chk("R5 upper-half read addr", last_addr2, 40'h030520);
    cmd(8'h50); adr(8'h00); adr(8'h00); adr(8'h01); settle();
    chk("R5 spare read addr", last_addr2, 40'h010200);
    cmd(8'h00); adr(8'h80); adr(8'h01); adr(8'h00); settle();
    chk("R14 x16 column byte address", last_addr2, 40'h000300);
    chk("R4 small page load kind", last_kind2, 2'd1);
    rd(v);
    chk("R4 x16 array data", v, 16'h1234);
    ce2_n = 1; ce_n = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; ce_n = 0;
    @(negedge clk);
    t_reset();
    t_status();
    t_deselect();
    t_ident();
    t_read_large();
    t_reset_cmd();
    t_program();
    t_erase();
    t_handshake();
    t_small();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule